// File: doc/BRIEF.md
# Selectable-Polynomial CRC Engine

This block accumulates a cyclic redundancy checksum over a stream of bytes. Software uses a small register port to choose one of three polynomials, to load the accumulator with all ones, to set a byte count and to start a run. While a run is active the block accepts bytes through a valid/ready stream port, which stands in for an upstream memory fetcher. When the run is complete it drops its busy flag, and the raw accumulator can be read back.

Each byte enters the checksum in reflected order: bit 0 is shifted in first and bit 7 last. Two modes use 32-bit polynomials (Ethernet and Castagnoli). The other modes use the 16-bit CCITT polynomial, which works on the low half of the accumulator only. The engine applies no final inversion. Successive runs with no clear between them therefore continue the same checksum.

Top module: `crc_engine`

## Requirements
- R1: After reset, `in_ready` is 0, the status word (address 3) reads 0, the result word (address 4) reads 0xFFFFFFFF, and the mode (address 1) and length (address 2) registers read 0.
- R2: A write to address 0 with bit 0 set, made while idle, loads the accumulator with 0xFFFFFFFF on the next clock edge.
- R3: Mode value 0 selects the reflected Ethernet polynomial 0xEDB88320, folded least significant bit first. The ASCII string "123456789" after a clear gives a result of 0x340BC6D9.
- R4: Mode value 1 selects the reflected Castagnoli polynomial 0x82F63B78. The same string gives 0x1CF96D7C.
- R5: Mode values 2 and 3 select the reflected 16-bit CCITT polynomial 0x8408, which acts on accumulator bits 15:0. The result reads zero-extended (bits 31:16 are 0). The same string gives 0x00006F91.
- R6: A write to address 0 with bit 1 set, made while idle with a nonzero length, sets busy (status bit 0) from the next cycle. `in_ready` equals busy, and a byte is absorbed only in a cycle where both `in_valid` and `in_ready` are high.
- R7: Exactly the programmed number of bytes is absorbed. Busy is low in the cycle after the edge that takes the last byte, and later bytes are not accepted.
- R8: A start request made while busy is ignored: the run does not restart and its remaining count is unchanged.
- R9: While busy, writes to the clear bit, the mode register and the length register are ignored.
- R10: A start request with a length of 0 is ignored, and busy stays low.
- R11: The result is the raw accumulator, with no final XOR. A run that follows another run with no clear in between continues from the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 control, 1 mode, 2 length |
| wr_data | input | 16 | Write data (control bit 0 clear, bit 1 start) |
| rd_addr | input | 3 | Read address: 1 mode, 2 length, 3 status, 4 result |
| rd_data | output | 32 | Combinational read data |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Stream ready, high while a run is active |

## Verification
The string "123456789" is run in every mode against published check values. This separates a wrong polynomial, a reversed bit order and an added final inversion. Pseudo-random bytes with irregular valid gaps, odd lengths and mode 3 are compared cycle by cycle against a bitwise model, which exposes mistakes in absorb timing and in the 16-bit masking. Splitting the string across two runs with no clear must give the single-run value, which shows that the accumulator carries over. Writes made during a run (start, clear, mode, length) and a start with a zero length must leave the ready, count and result behaviour unchanged.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int ADDR_W = 3;
  localparam int ACC_W  = 32;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE   = 3'd1;
  localparam logic [ADDR_W-1:0] A_LEN    = 3'd2;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd3;
  localparam logic [ADDR_W-1:0] A_RESULT = 3'd4;

  localparam logic [ACC_W-1:0] ACC_INIT = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {
    SEL_ETH   = 2'd0,
    SEL_CAST  = 2'd1,
    SEL_CCITT = 2'd2,
    SEL_CCALT = 2'd3
  } poly_sel_e;

  function automatic logic is_narrow(input poly_sel_e sel);
    return sel[1];
  endfunction

  function automatic logic [ACC_W-1:0] poly_of(input poly_sel_e sel);
    case (sel)
      SEL_ETH:  return 32'hEDB8_8320;
      SEL_CAST: return 32'h82F6_3B78;
      default:  return 32'h0000_8408;
    endcase
  endfunction

  // One byte, reflected: bit 0 of the byte enters first.
  function automatic logic [ACC_W-1:0] crc_byte(input logic [ACC_W-1:0] acc,
                                                input logic [7:0] b,
                                                input poly_sel_e sel);
    logic [ACC_W-1:0] c;
    logic [ACC_W-1:0] p;
    c = acc ^ {{(ACC_W-8){1'b0}}, b};
    p = poly_of(sel);
    for (int i = 0; i < 8; i++) begin
      if (is_narrow(sel))
        c[15:0] = c[0] ? ((c[15:0] >> 1) ^ p[15:0]) : (c[15:0] >> 1);
      else
        c = c[0] ? ((c >> 1) ^ p) : (c >> 1);
    end
    return c;
  endfunction

  function automatic logic [ACC_W-1:0] report(input logic [ACC_W-1:0] acc,
                                              input poly_sel_e sel);
    return is_narrow(sel) ? {16'h0, acc[15:0]} : acc;
  endfunction
endpackage

// File: rtl/crc_cfg.sv
module crc_cfg
  import crc_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LEN_W-1:0]  wr_data,
  input  logic              busy,
  output poly_sel_e         mode,
  output logic [LEN_W-1:0]  len,
  output logic              clr_pulse,
  output logic              go_pulse
);
  logic idle_wr;
  logic ctrl_hit;

  assign idle_wr   = wr_en && !busy;
  assign ctrl_hit  = idle_wr && (wr_addr == A_CTRL);
  assign clr_pulse = ctrl_hit && wr_data[0];
  assign go_pulse  = ctrl_hit && wr_data[1] && (len != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= SEL_ETH;
      len  <= '0;
    end else if (idle_wr) begin
      if (wr_addr == A_MODE) mode <= poly_sel_e'(wr_data[1:0]);
      if (wr_addr == A_LEN)  len  <= wr_data;
    end
  end

  // R9
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(mode) && $stable(len)));
endmodule

// File: rtl/crc_seq.sv
module crc_seq #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_pulse,
  input  logic [LEN_W-1:0] len,
  input  logic             byte_fire,
  output logic             busy,
  output logic             last_byte
);
  logic [LEN_W-1:0] remaining;

  assign last_byte = byte_fire && (remaining == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      remaining <= '0;
    end else if (go_pulse) begin
      busy      <= 1'b1;
      remaining <= len;
    end else if (byte_fire) begin
      remaining <= remaining - LEN_W'(1);
      if (last_byte) busy <= 1'b0;
    end
  end

  // R7
  last_clears_chk: assert property (@(posedge clk) disable iff (rst)
    last_byte |=> !busy);
  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !byte_fire) |=> (busy && remaining == $past(remaining)));
  // R10
  idle_stays_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !go_pulse) |=> !busy);
endmodule

// File: rtl/crc_acc.sv
module crc_acc
  import crc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_pulse,
  input  logic             byte_fire,
  input  logic [7:0]       byte_in,
  input  poly_sel_e        mode,
  output logic [ACC_W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (rst || clr_pulse) acc <= ACC_INIT;
    else if (byte_fire)   acc <= crc_byte(acc, byte_in, mode);
  end

  // R2
  clear_loads_chk: assert property (@(posedge clk) disable iff (rst)
    clr_pulse |=> (acc == ACC_INIT));
  // R11
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_pulse && !byte_fire) |=> $stable(acc));
endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LEN_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [ACC_W-1:0]  rd_data,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready
);
  poly_sel_e        mode;
  logic [LEN_W-1:0] len;
  logic             clr_pulse;
  logic             go_pulse;
  logic             busy;
  logic             last_byte;
  logic             byte_fire;
  logic [ACC_W-1:0] acc;

  assign in_ready  = busy;
  assign byte_fire = in_valid && busy;

  crc_cfg #(.LEN_W(LEN_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .mode(mode), .len(len), .clr_pulse(clr_pulse), .go_pulse(go_pulse)
  );

  crc_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .go_pulse(go_pulse), .len(len), .byte_fire(byte_fire),
    .busy(busy), .last_byte(last_byte)
  );

  crc_acc u_acc (
    .clk(clk), .rst(rst), .clr_pulse(clr_pulse), .byte_fire(byte_fire),
    .byte_in(in_data), .mode(mode), .acc(acc)
  );

  always_comb begin
    case (rd_addr)
      A_MODE:   rd_data = {{(ACC_W-2){1'b0}}, mode};
      A_LEN:    rd_data = {{(ACC_W-LEN_W){1'b0}}, len};
      A_STATUS: rd_data = {{(ACC_W-1){1'b0}}, busy};
      A_RESULT: rd_data = report(acc, mode);
      default:  rd_data = '0;
    endcase
  end

  // R5
  narrow_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == A_RESULT && is_narrow(mode)) |-> (rd_data[31:16] == 16'h0));
  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    go_pulse |=> in_ready);
  // R7
  last_idle_chk: assert property (@(posedge clk) disable iff (rst)
    last_byte |=> !in_ready);
endmodule

// File: tb/crc_engine_tb.sv
module crc_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = 3'd0;
  logic [15:0] wr_data = 16'd0;
  logic [2:0]  rd_addr = 3'd4;
  logic [31:0] rd_data;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'd0;
  logic        in_ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int seed   = 32'h1234_5678;

  always #2.5 clk = ~clk;

  crc_engine u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready)
  );

  // Bitwise reference: feedback bit taken per input bit, then shift.
  function automatic logic [31:0] ref_fold(input logic [31:0] a, input logic [7:0] b,
                                          input logic [1:0] m);
    logic [31:0] p;
    logic [15:0] s;
    logic fb;
    p = (m == 2'd0) ? 32'hEDB88320 : (m == 2'd1) ? 32'h82F63B78 : 32'h00008408;
    s = a[15:0];
    for (int i = 0; i < 8; i++) begin
      if (m[1]) begin
        fb = s[0] ^ b[i];
        s = s >> 1;
        if (fb) s = s ^ p[15:0];
      end else begin
        fb = a[0] ^ b[i];
        a = a >> 1;
        if (fb) a = a ^ p;
      end
    end
    if (m[1]) a[15:0] = s;
    return a;
  endfunction

  logic        m_busy;
  int          m_rem;
  logic [31:0] m_acc;
  logic [1:0]  m_mode;
  logic [15:0] m_len;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_rem = 0; m_acc = 32'hFFFFFFFF; m_mode = 0; m_len = 0;
    end else begin
      automatic logic was = m_busy;
      if (in_valid && was) begin
        m_acc = ref_fold(m_acc, in_data, m_mode);
        m_rem = m_rem - 1;
        if (m_rem == 0) m_busy = 0;
      end
      if (wr_en && !was) begin
        case (wr_addr)
          3'd0: begin
            if (wr_data[0]) m_acc = 32'hFFFFFFFF;
            if (wr_data[1] && m_len != 0) begin m_busy = 1; m_rem = m_len; end
          end
          3'd1: m_mode = wr_data[1:0];
          3'd2: m_len = wr_data;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] m_result();
    return m_mode[1] ? {16'h0, m_acc[15:0]} : m_acc;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model
  always begin
    @(posedge clk); #1;
    if (!rst && !done) begin
      chk(in_ready == m_busy, "R6 ready", {31'h0, in_ready}, {31'h0, m_busy});
      if (rd_addr == 3'd4)
        chk(rd_data == m_result(), m_mode == 0 ? "R3 acc" : m_mode == 1 ? "R4 acc" : "R5 acc",
            rd_data, m_result());
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_addr = a; #0.5;
    v = rd_data;
    rd_addr = 3'd4;
  endtask

  task automatic feed(input logic [7:0] b, input int gap);
    bit took;
    for (int g = 0; g < gap; g++) @(negedge clk);
    @(negedge clk);
    in_valid = 1; in_data = b;
    forever begin
      took = in_ready;
      @(posedge clk);
      if (took) break;
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (in_ready) @(negedge clk);
  endtask

  task automatic check_string(input logic [1:0] m, input logic [31:0] exp, input string req);
    logic [31:0] v;
    wr(3'd1, {14'h0, m});
    wr(3'd2, 16'd9);
    wr(3'd0, 16'h3);
    for (int i = 1; i <= 9; i++) feed(8'h30 + 8'(i), i % 3);
    wait_idle();
    rd(3'd3, v); chk(v == 0, req, v, 0);
    rd(3'd4, v); chk(v == exp, req, v, exp);
  endtask

  function automatic logic [7:0] nxt();
    seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
    return seed[7:0];
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(3'd3, v); chk(v == 0, "R1 status", v, 0);
    rd(3'd4, v); chk(v == 32'hFFFFFFFF, "R1 result", v, 32'hFFFFFFFF);
    rd(3'd1, v); chk(v == 0, "R1 mode", v, 0);
    rd(3'd2, v); chk(v == 0, "R1 len", v, 0);
    chk(in_ready == 0, "R1 ready", {31'h0, in_ready}, 0);

    check_string(2'd0, 32'h340BC6D9, "R3 check");
    check_string(2'd1, 32'h1CF96D7C, "R4 check");
    check_string(2'd2, 32'h00006F91, "R5 check");

    // R11 split run without clear continues the sum
    wr(3'd1, 16'd0); wr(3'd0, 16'h1);
    rd(3'd4, v); chk(v == 32'hFFFFFFFF, "R2 clear", v, 32'hFFFFFFFF);
    wr(3'd2, 16'd4); wr(3'd0, 16'h2);
    for (int i = 1; i <= 4; i++) feed(8'h30 + 8'(i), 0);
    wait_idle();
    wr(3'd2, 16'd5); wr(3'd0, 16'h2);
    for (int i = 5; i <= 9; i++) feed(8'h30 + 8'(i), 1);
    wait_idle();
    rd(3'd4, v); chk(v == 32'h340BC6D9, "R11 split", v, 32'h340BC6D9);

    // R8/R9 writes during a run; R7 extra bytes refused
    wr(3'd1, 16'd1); wr(3'd0, 16'h1); wr(3'd2, 16'd4); wr(3'd0, 16'h2);
    feed(8'hA5, 0);
    wr(3'd0, 16'h3);           // start+clear while busy
    wr(3'd1, 16'd2);           // mode while busy
    wr(3'd2, 16'd7);           // length while busy
    feed(8'h5A, 0); feed(8'h00, 2); feed(8'hFF, 0);
    @(negedge clk);
    chk(in_ready == 0, "R7 done after 4", {31'h0, in_ready}, 0);
    in_valid = 1; in_data = 8'h77;
    repeat (3) @(negedge clk);
    chk(in_ready == 0, "R7 extra refused", {31'h0, in_ready}, 0);
    in_valid = 0;
    rd(3'd1, v); chk(v == 1, "R9 mode kept", v, 1);
    rd(3'd2, v); chk(v == 4, "R9 len kept", v, 4);
    rd(3'd4, v); chk(v == m_result(), "R8 result", v, m_result());

    // R10 zero length
    wr(3'd2, 16'd0); wr(3'd0, 16'h2);
    @(negedge clk);
    chk(in_ready == 0, "R10 zero len", {31'h0, in_ready}, 0);
    rd(3'd3, v); chk(v == 0, "R10 status", v, 0);

    // Random runs in all modes, mode 3 included
    for (int r = 0; r < 12; r++) begin
      wr(3'd1, {14'h0, 2'(r % 4)});
      if (r % 2 == 0) wr(3'd0, 16'h1);
      wr(3'd2, 16'(1 + (r * 7) % 23));
      wr(3'd0, 16'h2);
      for (int i = 0; i < 1 + (r * 7) % 23; i++) begin
        automatic logic [7:0] b = nxt();
        feed(b, b[1:0] == 0 ? 2 : 0);
      end
      wait_idle();
      rd(3'd4, v);
      chk(v == m_result(), r % 4 == 0 ? "R3 rand" : r % 4 == 1 ? "R4 rand" : "R5 rand",
          v, m_result());
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule